// File: doc/BRIEF.md
# Soft-Ramped Stereo Attenuator with Mute

This block scales a stereo pair of signed audio samples ahead of the oversampling and modulator chain. Each channel has its own 8-bit attenuation code and its own ramp position. The applied gain never jumps to a new code. On every sample strobe the ramp position moves by at most one fine step toward its target, so volume changes cannot cause clicks.

A soft-mute request moves the target of both channels to silence. The ramp then walks down from wherever it stands. When the request drops, the ramp climbs back to the programmed level at the same rate. If the request drops part-way down, the ramp turns round at once. A fade-hold input pins both channels at 0 dB. When it is released, the gain fades to the programmed level.

The ramp position selects a linear gain. That gain comes from a twelve-entry mantissa table for one 6 dB octave, an arithmetic right shift per octave, and linear interpolation across the fine sub-steps inside a code. The sample is multiplied by the gain, rounded and saturated.

Top module: `stereo_soft_att`

## Requirements
- R1: The code sets the gain. Code FFh is unity gain, so the output equals the input. Each lower code adds 0.5 dB of attenuation, so 01h is −127 dB. Every 12 codes below FFh halve the gain exactly: F3h gives one half, E7h one quarter and DBh one eighth. Code 00h gives an output of exactly zero.
- R2: Each channel holds a ramp position from 0 to 7424. The target position is (code+1)×29 for codes 01h..FFh and 0 for code 00h. On a cycle with sampleStb high, the position moves one step toward the target. Without a strobe it does not move.
- R3: A full swing from code FFh to code 00h takes exactly 7424 strobes. After 7423 strobes the position is 1, and after 7424 strobes it is 0.
- R4: The left and right channels have independent codes and independent ramp positions. Changing one channel's code leaves the other channel's position and output unchanged.
- R5: While muteReq is high, the target of both channels is position 0, whatever the codes are. The output then reaches exactly zero. When muteReq goes low, the ramp climbs back to the code's target, one step per strobe.
- R6: If muteReq drops before position 0 is reached, the ramp reverses on the next strobe. It then climbs one step per strobe and settles at the code's target.
- R7: While fadeHold is high, both positions are 7424 (0 dB) from the next clock on. After fadeHold is released, the positions ramp one step per strobe to the programmed targets.
- R8: The outputs are registered. outValid is high in the cycle after a strobe. The output sample uses the gain of the position held before that strobe. The product is rounded to the nearest integer, with halves going toward plus infinity, and saturated to the sample width. Between strobes the output holds its value.
- R9: After reset both positions are 7424, both outputs are 0 and outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle strobe per sample period |
| leftIn | input | SW | Left signed input sample |
| rightIn | input | SW | Right signed input sample |
| leftCode | input | 8 | Left attenuation code |
| rightCode | input | 8 | Right attenuation code |
| muteReq | input | 1 | Soft-mute request |
| fadeHold | input | 1 | Holds both channels at 0 dB |
| leftOut | output | SW | Left attenuated sample |
| rightOut | output | SW | Right attenuated sample |
| outValid | output | 1 | Output samples updated this cycle |
| levelL | output | 13 | Left ramp position |
| levelR | output | 13 | Right ramp position |

## Verification
The table walk settles both channels at the octave-aligned codes (FFh, F3h, E7h, DBh and 00h). It applies odd, even, full-scale positive and full-scale negative samples, which separates correct rounding and sign handling from plain truncation. Directed ramps check the following:
- the exact 7423 and 7424 strobe counts of a full swing, which expose an off-by-one in the step or target mapping;
- a mute stopped after 1000 steps, which must climb back rather than finish the mute;
- a one-sided code change, which exposes any coupling between the channels.

A single strobe taken on a fresh code shows that the output uses the gain from before that step.

// File: rtl/satt_pkg.sv
package satt_pkg;
  localparam int CODE_W    = 8;
  localparam int SUB_STEPS = 29;
  localparam int SUB_W     = $clog2(SUB_STEPS);
  localparam int COARSE_W  = CODE_W + 1;
  localparam int LEVEL_MAX = (1 << CODE_W) * SUB_STEPS;
  localparam int LEVEL_W   = $clog2(LEVEL_MAX + 1);
  localparam int GAIN_W    = 16;
  localparam int UNITY_SH  = GAIN_W - 1;
  localparam int OCT       = 12;
  localparam int INV_SH    = 14;
  localparam int INV_SUB   = ((1 << INV_SH) + SUB_STEPS / 2) / SUB_STEPS;

  typedef struct packed {
    logic [COARSE_W-1:0] coarse;
    logic [SUB_W-1:0]    sub;
  } rampPos_t;

  typedef struct packed {
    logic              stb;
    rampPos_t [1:0]    pos;
  } gainCtl_t;

  // unity = 2^15, entry i is 10^(-i/40), i.e. i half-dB steps down
  function automatic logic [GAIN_W-1:0] mantissa(input int idx);
    case (idx)
      0:  return 16'd32768;
      1:  return 16'd30935;
      2:  return 16'd29205;
      3:  return 16'd27571;
      4:  return 16'd26029;
      5:  return 16'd24573;
      6:  return 16'd23198;
      7:  return 16'd21901;
      8:  return 16'd20675;
      9:  return 16'd19519;
      10: return 16'd18427;
      default: return 16'd17396;
    endcase
  endfunction

  function automatic logic [GAIN_W-1:0] gainAt(input int k);
    int sh;
    sh = k / OCT;
    return mantissa(k % OCT) >> sh;
  endfunction

  function automatic logic [GAIN_W-1:0] blend(input logic [GAIN_W-1:0] lo,
                                             input logic [GAIN_W-1:0] hi,
                                             input int sub);
    int d;
    d = (int'(hi) - int'(lo)) * sub * INV_SUB;
    return lo + GAIN_W'(d >>> INV_SH);
  endfunction
endpackage

// File: rtl/satt_ramp_ctrl.sv
module satt_ramp_ctrl
  import satt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sampleStb,
  input  logic [1:0][CODE_W-1:0] codes,
  input  logic                   muteReq,
  input  logic                   fadeHold,
  output gainCtl_t               ctl
);
  localparam logic [COARSE_W-1:0] TOP_COARSE = COARSE_W'(1 << CODE_W);
  localparam logic [SUB_W-1:0]    SUB_LAST   = SUB_W'(SUB_STEPS - 1);

  assign ctl.stb = sampleStb;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    rampPos_t            pos;
    logic [COARSE_W-1:0] tgt;
    logic                above, below;

    always_comb begin
      if (muteReq || codes[ch] == '0) tgt = '0;
      else                            tgt = COARSE_W'(codes[ch]) + 1'b1;
      above = (pos.coarse > tgt) || (pos.coarse == tgt && pos.sub != '0);
      below = (pos.coarse < tgt);
    end

    always_ff @(posedge clk) begin
      if (!rst_n || fadeHold) begin
        pos.coarse <= TOP_COARSE;
        pos.sub    <= '0;
      end else if (sampleStb) begin
        if (above) begin
          if (pos.sub == '0) begin
            pos.coarse <= pos.coarse - 1'b1;
            pos.sub    <= SUB_LAST;
          end else begin
            pos.sub <= pos.sub - 1'b1;
          end
        end else if (below) begin
          if (pos.sub == SUB_LAST) begin
            pos.coarse <= pos.coarse + 1'b1;
            pos.sub    <= '0;
          end else begin
            pos.sub <= pos.sub + 1'b1;
          end
        end
      end
    end

    assign ctl.pos[ch] = pos;
  end
endmodule

// File: rtl/satt_gain_path.sv
module satt_gain_path
  import satt_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  gainCtl_t           ctl,
  input  logic [1:0][SW-1:0] samplesIn,
  output logic [1:0][SW-1:0] samplesOut,
  output logic               outValid
);
  localparam int PW = SW + GAIN_W + 1;
  localparam logic signed [PW-1:0] ROUND_C = PW'(1) <<< (UNITY_SH - 1);
  localparam logic signed [PW-1:0] MAX_C   = PW'((1 << (SW - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_C   = -(PW'(1) <<< (SW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= ctl.stb;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    int                       kIdx;
    logic [GAIN_W-1:0]        gLo, gHi, gain;
    logic signed [PW-1:0]     prod, scaled;
    logic signed [SW-1:0]     clipped;

    always_comb begin
      kIdx = (1 << CODE_W) - int'(ctl.pos[ch].coarse);
      gLo  = gainAt(kIdx);
      gHi  = (kIdx == 0) ? gLo : gainAt(kIdx - 1);
      if (ctl.pos[ch].coarse == '0 && ctl.pos[ch].sub == '0) gain = '0;
      else gain = blend(gLo, gHi, int'(ctl.pos[ch].sub));
      prod   = PW'($signed(samplesIn[ch])) * $signed({1'b0, gain});
      scaled = (prod + ROUND_C) >>> UNITY_SH;
      if (scaled > MAX_C)      clipped = MAX_C[SW-1:0];
      else if (scaled < MIN_C) clipped = MIN_C[SW-1:0];
      else                     clipped = scaled[SW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       samplesOut[ch] <= '0;
      else if (ctl.stb) samplesOut[ch] <= clipped;
    end
  end
endmodule

// File: rtl/stereo_soft_att.sv
module stereo_soft_att
  import satt_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleStb,
  input  logic [SW-1:0]      leftIn,
  input  logic [SW-1:0]      rightIn,
  input  logic [CODE_W-1:0]  leftCode,
  input  logic [CODE_W-1:0]  rightCode,
  input  logic               muteReq,
  input  logic               fadeHold,
  output logic [SW-1:0]      leftOut,
  output logic [SW-1:0]      rightOut,
  output logic               outValid,
  output logic [LEVEL_W-1:0] levelL,
  output logic [LEVEL_W-1:0] levelR
);
  gainCtl_t           ctl;
  logic [1:0][SW-1:0] outs;

  satt_ramp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb),
    .codes({rightCode, leftCode}), .muteReq(muteReq), .fadeHold(fadeHold),
    .ctl(ctl)
  );

  satt_gain_path #(.SW(SW)) u_path (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .samplesIn({rightIn, leftIn}), .samplesOut(outs), .outValid(outValid)
  );

  assign leftOut  = outs[0];
  assign rightOut = outs[1];
  assign levelL = LEVEL_W'(ctl.pos[0].coarse) * LEVEL_W'(SUB_STEPS) + LEVEL_W'(ctl.pos[0].sub);
  assign levelR = LEVEL_W'(ctl.pos[1].coarse) * LEVEL_W'(SUB_STEPS) + LEVEL_W'(ctl.pos[1].sub);
endmodule

// File: rtl/satt_checker.sv
module satt_checker
  import satt_pkg::*;
#(
  parameter int SW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sampleStb,
  input logic               muteReq,
  input logic               fadeHold,
  input logic [SW-1:0]      leftOut,
  input logic               outValid,
  input logic [LEVEL_W-1:0] levelL,
  input logic [LEVEL_W-1:0] levelR
);
  AST_STEP_ONE_L: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb && !fadeHold |=> (levelL == $past(levelL) || levelL == $past(levelL) + 1'b1
                                || levelL + 1'b1 == $past(levelL))); // R2
  AST_STEP_ONE_R: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb && !fadeHold |=> (levelR == $past(levelR) || levelR == $past(levelR) + 1'b1
                                || levelR + 1'b1 == $past(levelR))); // R4
  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStb && !fadeHold |=> $stable(levelL) && $stable(levelR)); // R2
  AST_MUTE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb && muteReq && !fadeHold && levelL != '0 |=> levelL + 1'b1 == $past(levelL)); // R5
  AST_FADE_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    fadeHold |=> levelL == LEVEL_W'(LEVEL_MAX) && levelR == LEVEL_W'(LEVEL_MAX)); // R7
  AST_SILENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb && levelL == '0 |=> leftOut == '0); // R1
  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStb |=> outValid); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStb |=> !outValid); // R8
endmodule

bind stereo_soft_att satt_checker #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .muteReq(muteReq),
  .fadeHold(fadeHold), .leftOut(leftOut), .outValid(outValid),
  .levelL(levelL), .levelR(levelR)
);

// File: tb/stereo_soft_att_bench.sv
module stereo_soft_att_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int NVEC = 9;
  localparam int VEC_CODE [NVEC] = '{255, 255, 243, 243, 231, 231, 219, 0, 255};
  localparam int VEC_IN   [NVEC] = '{12345, -32768, 1001, -1001, 1002, -32768, 100, 32767, 32767};
  localparam int VEC_EXP  [NVEC] = '{12345, -32768, 501, -500, 251, -8192, 13, 0, 32767};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleStb = 1'b0;
  logic [SW-1:0] leftIn = '0, rightIn = '0;
  logic [7:0] leftCode = 8'hFF, rightCode = 8'hFF;
  logic muteReq = 1'b0, fadeHold = 1'b0;
  logic [SW-1:0] leftOut, rightOut;
  logic outValid;
  logic [12:0] levelL, levelR;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_soft_att #(.SW(SW)) u_stereo_soft_att (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .leftIn(leftIn), .rightIn(rightIn),
    .leftCode(leftCode), .rightCode(rightCode), .muteReq(muteReq), .fadeHold(fadeHold),
    .leftOut(leftOut), .rightOut(rightOut), .outValid(outValid),
    .levelL(levelL), .levelR(levelR)
  );

  task automatic check(input string what, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, actual, expected);
    end
  endtask

  // starts and ends at a falling edge; exactly n rising edges see the strobe
  task automatic runStb(input int n);
    sampleStb = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  function automatic int tgtLevel(input int code);
    return (code == 0) ? 0 : (code + 1) * 29;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset levelL", int'(levelL), 7424);
    check("R9 reset levelR", int'(levelR), 7424);
    check("R9 reset outValid", int'(outValid), 0);
    check("R9 reset leftOut", int'($signed(leftOut)), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: gain of the position before the strobe, output valid one cycle later
    leftCode = 8'hF3; leftIn = 16'sd1000; rightIn = 16'sd1000;
    runStb(1);
    check("R8 leftOut uses old gain", int'($signed(leftOut)), 1000);
    check("R8 outValid after strobe", int'(outValid), 1);
    check("R8 levelL stepped", int'(levelL), 7423);
    @(negedge clk);
    check("R8 outValid idle", int'(outValid), 0);
    check("R8 leftOut held", int'($signed(leftOut)), 1000);
    check("R2 no step without strobe", int'(levelL), 7423);

    // R4: one-sided code change
    runStb(347);
    check("R4 levelL at F3", int'(levelL), 7076);
    check("R4 levelR untouched", int'(levelR), 7424);
    runStb(1);
    check("R4 leftOut half", int'($signed(leftOut)), 500);
    check("R4 rightOut unity", int'($signed(rightOut)), 1000);

    // R7: fade hold pins 0 dB, release ramps down
    fadeHold = 1'b1;
    @(negedge clk);
    check("R7 hold levelL", int'(levelL), 7424);
    fadeHold = 1'b0;
    runStb(200);
    check("R7 fade partway", int'(levelL), 7224);
    runStb(148);
    check("R7 fade settled", int'(levelL), 7076);
    leftCode = 8'hFF;
    runStb(348);
    check("R2 back to FF", int'(levelL), 7424);

    // R3: full swing timing
    leftCode = 8'h00;
    runStb(7423);
    check("R3 swing 7423", int'(levelL), 1);
    check("R4 right still unity", int'(levelR), 7424);
    runStb(1);
    check("R3 swing 7424", int'(levelL), 0);
    runStb(5);
    check("R3 stays at zero", int'(levelL), 0);
    leftCode = 8'hFF;
    runStb(7424);
    check("R3 swing back up", int'(levelL), 7424);

    // R6: reversal part-way
    muteReq = 1'b1;
    runStb(1000);
    check("R6 mute partway L", int'(levelL), 6424);
    check("R6 mute partway R", int'(levelR), 6424);
    muteReq = 1'b0;
    runStb(400);
    check("R6 reversed", int'(levelL), 6824);
    runStb(610);
    check("R6 settled", int'(levelL), 7424);

    // R5: full mute
    muteReq = 1'b1; leftIn = 16'sd20000; rightIn = -16'sd20000;
    runStb(7424);
    check("R5 muted levelR", int'(levelR), 0);
    runStb(1);
    check("R5 muted leftOut", int'($signed(leftOut)), 0);
    check("R5 muted rightOut", int'($signed(rightOut)), 0);
    muteReq = 1'b0;
    runStb(7424);
    check("R5 released", int'(levelL), 7424);

    // R1/R8: table of settled codes
    for (int i = 0; i < NVEC; i++) begin
      leftCode = 8'(VEC_CODE[i]); rightCode = 8'(VEC_CODE[i]);
      leftIn = SW'(VEC_IN[i]); rightIn = SW'(VEC_IN[i]);
      runStb(7430);
      check("R1 vector levelL", int'(levelL), tgtLevel(VEC_CODE[i]));
      check("R1 R8 vector leftOut", int'($signed(leftOut)), VEC_EXP[i]);
      check("R1 R8 vector rightOut", int'($signed(rightOut)), VEC_EXP[i]);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule